// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two 16-bit parallel buses, A and B. It is built as two 8-bit halves that work on their own, and each half has its own set of controls. In each half, one input picks the transfer direction and an enable input lets the half drive the bus on the receiving side. Each direction has a capture register and a source select. The select forwards either the live value of the opposite bus, which makes the path transparent, or the value last captured in that direction's register, which makes the path registered.

The buses are modelled with two-state signals and no inout ports. For every bit of each bus, the outside world gives a data value and a drive enable. The block reports which side of each half it drives, and it returns the resolved level of every line. A bus-hold keeper gives a line that nobody drives the level it last carried while it was driven. No pull resistors are modelled.

A rising edge on a capture strobe stores the resolved bus level into that direction's register. The strobe is sampled by the core clock. Capture works whatever the direction and enable inputs are set to, so data can be stored while the outputs are off.

Top module: `bus_xcvr16`

## Requirements
- R1: Each 8-bit half (bits 7:0 = half 0, bits 15:8 = half 1) responds only to its own control bits. The controls of one half never change the drive or the line levels of the other half.
- R2: With `out_en[h]`=1, `dir_atob[h]`=1 makes the block drive B and not A in that half (`b_drv_en[h]`=1, `a_drv_en[h]`=0). `dir_atob[h]`=0 makes it drive A and not B.
- R3: With `out_en[h]`=0 the block drives neither side of half h, and both drive flags of that half read 0.
- R4: A capture register loads the resolved line value at the first clock edge at which its strobe is seen high after being seen low. Direction and enable do not matter. At every other edge, including edges while the strobe stays high, the register holds.
- R5: When B is driven, `sel_ab_reg[h]`=0 passes the current resolved A level to B in the same cycle. `sel_ab_reg[h]`=1 drives B from the A-to-B register.
- R6: When A is driven, `sel_ba_reg[h]`=0 passes the current resolved B level to A in the same cycle. `sel_ba_reg[h]`=1 drives A from the B-to-A register.
- R7: The select of the direction that is not being driven has no effect on either bus.
- R8: A line driven by neither the block nor the outside shows the level it had at the last clock edge at which it was driven.
- R9: After a synchronous active-low reset, both registers of each half and all keepers hold zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; samples strobes, updates registers and keepers |
| rst_n | input | 1 | Synchronous active-low reset |
| dir_atob | input | 2 | Per half: 1 = A to B, 0 = B to A |
| out_en | input | 2 | Per half: 1 lets the block drive the selected side |
| sel_ab_reg | input | 2 | Per half: 1 = B gets stored A-to-B value, 0 = live A |
| sel_ba_reg | input | 2 | Per half: 1 = A gets stored B-to-A value, 0 = live B |
| cap_ab | input | 2 | Per half: capture strobe for the A-to-B register |
| cap_ba | input | 2 | Per half: capture strobe for the B-to-A register |
| a_ext_data | input | 16 | Value driven onto bus A from outside |
| a_ext_en | input | 16 | Per-bit outside drive enable on bus A |
| b_ext_data | input | 16 | Value driven onto bus B from outside |
| b_ext_en | input | 16 | Per-bit outside drive enable on bus B |
| a_line | output | 16 | Resolved level of bus A |
| b_line | output | 16 | Resolved level of bus B |
| a_drv_en | output | 2 | Per half: block drives bus A |
| b_drv_en | output | 2 | Per half: block drives bus B |

## Verification
The bench holds a capture strobe high over several clock edges while the data changes. A design that captures on level rather than on edge would end up holding the later value. The bench captures data while the outputs are off and then changes the live bus before enabling, so a design that mixed up live and stored sources, or that gated capture on enable, would show the wrong byte. It releases only some bits of a bus, and also stops the block's own drive, to catch a keeper that floats to zero or holds a stale value. It also toggles the unused direction's select and drives one half only, which catches cross-coupling between directions or halves. A monitor flags any cycle in which the block and the outside drive the same line.

// File: rtl/xcvr_pkg.sv
// Shared definitions for the registered bus transceiver.
// Assumes: direction encoding is a single bit per half.
package xcvr_pkg;
    typedef enum logic {
        XFER_B_TO_A = 1'b0,
        XFER_A_TO_B = 1'b1
    } xfer_dir_e;
endpackage

// File: rtl/xcvr_edge_capture.sv
// Capture register with strobe edge detection.
// Loads din at the first core-clock edge at which the strobe is seen high
// after it was seen low; holds otherwise.
// Assumes: strobe is synchronous to clk or already synchronised upstream.
module xcvr_edge_capture #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] q
);
    logic strobe_prev;
    logic rise;

    // Purpose: flag a low-to-high transition of the strobe.
    always_comb begin
        rise = strobe && !strobe_prev;
    end

    // Purpose: remember the last sampled strobe level.
    always_ff @(posedge clk) begin
        if (!rst_n) strobe_prev <= 1'b0;
        else        strobe_prev <= strobe;
    end

    // Purpose: load the register on a detected rising strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (rise) q <= din;
    end

    // R4: a rising strobe loads the line value seen at that edge
    p_load_on_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> q == $past(din));

    // R4: without a rising strobe the register keeps its value
    p_hold_no_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !rise |=> $stable(q));
endmodule

// File: rtl/xcvr_side_keeper.sv
// Line resolution and bus-hold keeper for one side of one half.
// The block's own driver wins when enabled. Otherwise each bit takes the
// outside driver when that is enabled, and the keeper level when nothing drives.
// The keeper samples every driven bit at each clock edge.
// Assumes: the block and the outside never drive the same bit together.
module xcvr_side_keeper #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             blk_en,
    input  logic [WIDTH-1:0] blk_data,
    input  logic [WIDTH-1:0] ext_en,
    input  logic [WIDTH-1:0] ext_data,
    output logic [WIDTH-1:0] outside,
    output logic [WIDTH-1:0] line
);
    logic [WIDTH-1:0] keep;
    logic [WIDTH-1:0] driven;

    // Purpose: level seen from outside the block (outside driver or keeper).
    always_comb begin
        outside = (ext_en & ext_data) | (~ext_en & keep);
    end

    // Purpose: final resolved level including the block's own driver.
    always_comb begin
        line   = blk_en ? blk_data : outside;
        driven = ext_en | {WIDTH{blk_en}};
    end

    // Purpose: keeper follows each driven bit and holds undriven bits.
    always_ff @(posedge clk) begin
        if (!rst_n) keep <= '0;
        else        keep <= (driven & line) | (~driven & keep);
    end

    // R8: undriven bits keep their previous level
    p_keep_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((keep ^ $past(keep)) & ~$past(driven)) == '0);

    // R8: driven bits are remembered by the keeper
    p_keep_track_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((keep ^ $past(line)) & $past(driven)) == '0);
endmodule

// File: rtl/xcvr_half.sv
// One 8-bit transceiver half: two capture registers, two source selects,
// direction/enable gating and a keeper on each side.
// Assumes: only one side of the half is ever driven by the block.
module xcvr_half
    import xcvr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dir_atob,
    input  logic             out_en,
    input  logic             sel_ab_reg,
    input  logic             sel_ba_reg,
    input  logic             cap_ab,
    input  logic             cap_ba,
    input  logic [WIDTH-1:0] a_ext_data,
    input  logic [WIDTH-1:0] a_ext_en,
    input  logic [WIDTH-1:0] b_ext_data,
    input  logic [WIDTH-1:0] b_ext_en,
    output logic [WIDTH-1:0] a_line,
    output logic [WIDTH-1:0] b_line,
    output logic             a_drv_en,
    output logic             b_drv_en
);
    xfer_dir_e        dir;
    logic [WIDTH-1:0] reg_ab;
    logic [WIDTH-1:0] reg_ba;
    logic [WIDTH-1:0] a_outside;
    logic [WIDTH-1:0] b_outside;
    logic [WIDTH-1:0] a_src;
    logic [WIDTH-1:0] b_src;

    // Purpose: decode direction and gate the drive enables.
    always_comb begin
        dir      = xfer_dir_e'(dir_atob);
        b_drv_en = out_en && (dir == XFER_A_TO_B);
        a_drv_en = out_en && (dir == XFER_B_TO_A);
    end

    // Purpose: pick live or stored data for each direction.
    always_comb begin
        b_src = sel_ab_reg ? reg_ab : a_outside;
        a_src = sel_ba_reg ? reg_ba : b_outside;
    end

    xcvr_edge_capture #(.WIDTH(WIDTH)) u_cap_ab (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (cap_ab),
        .din    (a_line),
        .q      (reg_ab)
    );

    xcvr_edge_capture #(.WIDTH(WIDTH)) u_cap_ba (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (cap_ba),
        .din    (b_line),
        .q      (reg_ba)
    );

    xcvr_side_keeper #(.WIDTH(WIDTH)) u_side_a (
        .clk      (clk),
        .rst_n    (rst_n),
        .blk_en   (a_drv_en),
        .blk_data (a_src),
        .ext_en   (a_ext_en),
        .ext_data (a_ext_data),
        .outside  (a_outside),
        .line     (a_line)
    );

    xcvr_side_keeper #(.WIDTH(WIDTH)) u_side_b (
        .clk      (clk),
        .rst_n    (rst_n),
        .blk_en   (b_drv_en),
        .blk_data (b_src),
        .ext_en   (b_ext_en),
        .ext_data (b_ext_data),
        .outside  (b_outside),
        .line     (b_line)
    );

    // R2: never both sides of a half at once
    p_one_side_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_drv_en && b_drv_en));

    // R5: transparent A-to-B path mirrors the A line on B
    p_transparent_ab_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_en && dir_atob && !sel_ab_reg) |-> b_line == a_line);

    // R6: stored B-to-A path shows the register on A
    p_stored_ba_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_en && !dir_atob && sel_ba_reg) |-> a_line == reg_ba);

    // R3: disabled half lets the outside value through on both sides
    p_disabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |-> (a_line == a_outside) && (b_line == b_outside));
endmodule

// File: rtl/bus_xcvr16.sv
// Top of the registered bidirectional bus transceiver: replicates one
// independent half per slice of the buses.
// Assumes: outside drivers are per bit; block drive is per half.
module bus_xcvr16 #(
    parameter int HALF_W    = 8,
    parameter int NUM_HALF  = 2,
    localparam int BUS_W    = HALF_W * NUM_HALF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_HALF-1:0] dir_atob,
    input  logic [NUM_HALF-1:0] out_en,
    input  logic [NUM_HALF-1:0] sel_ab_reg,
    input  logic [NUM_HALF-1:0] sel_ba_reg,
    input  logic [NUM_HALF-1:0] cap_ab,
    input  logic [NUM_HALF-1:0] cap_ba,
    input  logic [BUS_W-1:0]    a_ext_data,
    input  logic [BUS_W-1:0]    a_ext_en,
    input  logic [BUS_W-1:0]    b_ext_data,
    input  logic [BUS_W-1:0]    b_ext_en,
    output logic [BUS_W-1:0]    a_line,
    output logic [BUS_W-1:0]    b_line,
    output logic [NUM_HALF-1:0] a_drv_en,
    output logic [NUM_HALF-1:0] b_drv_en
);
    // Purpose: one independent transceiver per slice (R1).
    for (genvar h = 0; h < NUM_HALF; h++) begin : g_half
        xcvr_half #(.WIDTH(HALF_W)) u_half (
            .clk        (clk),
            .rst_n      (rst_n),
            .dir_atob   (dir_atob[h]),
            .out_en     (out_en[h]),
            .sel_ab_reg (sel_ab_reg[h]),
            .sel_ba_reg (sel_ba_reg[h]),
            .cap_ab     (cap_ab[h]),
            .cap_ba     (cap_ba[h]),
            .a_ext_data (a_ext_data[h*HALF_W +: HALF_W]),
            .a_ext_en   (a_ext_en[h*HALF_W +: HALF_W]),
            .b_ext_data (b_ext_data[h*HALF_W +: HALF_W]),
            .b_ext_en   (b_ext_en[h*HALF_W +: HALF_W]),
            .a_line     (a_line[h*HALF_W +: HALF_W]),
            .b_line     (b_line[h*HALF_W +: HALF_W]),
            .a_drv_en   (a_drv_en[h]),
            .b_drv_en   (b_drv_en[h])
        );
    end
endmodule

// File: tb/bus_xcvr16_test.sv
// Directed bench for bus_xcvr16: one task per scenario, each checking itself.
module bus_xcvr16_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  dir_atob = '0, out_en = '0, sel_ab_reg = '0, sel_ba_reg = '0;
    logic [1:0]  cap_ab = '0, cap_ba = '0;
    logic [15:0] a_ext_data = '0, a_ext_en = '0, b_ext_data = '0, b_ext_en = '0;
    logic [15:0] a_line, b_line;
    logic [1:0]  a_drv_en, b_drv_en;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    bus_xcvr16 uut (
        .clk(clk), .rst_n(rst_n), .dir_atob(dir_atob), .out_en(out_en),
        .sel_ab_reg(sel_ab_reg), .sel_ba_reg(sel_ba_reg),
        .cap_ab(cap_ab), .cap_ba(cap_ba),
        .a_ext_data(a_ext_data), .a_ext_en(a_ext_en),
        .b_ext_data(b_ext_data), .b_ext_en(b_ext_en),
        .a_line(a_line), .b_line(b_line),
        .a_drv_en(a_drv_en), .b_drv_en(b_drv_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Contention monitor (R2, R3): block and outside never drive the same half-line.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int h = 0; h < 2; h++) begin
                if ((a_drv_en[h] && |a_ext_en[h*8 +: 8]) ||
                    (b_drv_en[h] && |b_ext_en[h*8 +: 8])) begin
                    total++;
                    fails++;
                    $display("FAIL R2 contention half %0d: actual a%b b%b expected no overlap",
                             h, a_drv_en, b_drv_en);
                end
            end
        end
    end

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        chk("R9", "a keeper", a_line, 16'h0000);
        chk("R9", "b keeper", b_line, 16'h0000);
        chk("R3", "no drive off", {a_drv_en, b_drv_en}, 4'b0000);
        dir_atob = 2'b11; sel_ab_reg = 2'b11; out_en = 2'b11; #1;
        chk("R9", "ab reg zero", b_line, 16'h0000);
        chk("R2", "drive B only", {a_drv_en, b_drv_en}, 4'b0011);
        dir_atob = 2'b00; sel_ba_reg = 2'b11; #1;
        chk("R9", "ba reg zero", a_line, 16'h0000);
        chk("R2", "drive A only", {a_drv_en, b_drv_en}, 4'b1100);
        out_en = 2'b00;
        tick();
    endtask

    task automatic t_transparent_ab();
        out_en = 2'b00; b_ext_en = '0;
        a_ext_en = 16'hFFFF; a_ext_data = 16'h1234;
        dir_atob = 2'b11; sel_ab_reg = 2'b00; out_en = 2'b11; #1;
        chk("R5", "live A to B", b_line, 16'h1234);
        a_ext_data = 16'hABCD; #1;
        chk("R5", "live follows same cycle", b_line, 16'hABCD);
        tick();
        out_en = 2'b00;
        tick();
    endtask

    task automatic t_store_ab();
        out_en = 2'b00; b_ext_en = '0; dir_atob = 2'b11;
        a_ext_en = 16'hFFFF; a_ext_data = 16'h5AA5;
        tick();
        cap_ab = 2'b11;
        tick();
        a_ext_data = 16'h0F0F;
        tick();
        cap_ab = 2'b00;
        tick();
        chk("R3", "disabled during capture", {a_drv_en, b_drv_en}, 4'b0000);
        sel_ab_reg = 2'b11; out_en = 2'b11; #1;
        chk("R4", "first edge captured while disabled", b_line, 16'h5AA5);
        sel_ab_reg = 2'b00; #1;
        chk("R5", "live after store", b_line, 16'h0F0F);
        out_en = 2'b00;
        tick();
    endtask

    task automatic t_store_ba();
        out_en = 2'b00; a_ext_en = '0; dir_atob = 2'b00;
        b_ext_en = 16'hFFFF; b_ext_data = 16'h9669;
        tick();
        cap_ba = 2'b11;
        tick();
        cap_ba = 2'b00;
        b_ext_data = 16'h2C2C;
        tick();
        sel_ba_reg = 2'b11; out_en = 2'b11; #1;
        chk("R6", "stored B to A", a_line, 16'h9669);
        chk("R2", "drive A dir 0", {a_drv_en, b_drv_en}, 4'b1100);
        sel_ba_reg = 2'b00; #1;
        chk("R6", "live B to A", a_line, 16'h2C2C);
        out_en = 2'b00;
        tick();
    endtask

    task automatic t_unused_sel();
        out_en = 2'b00; b_ext_en = '0;
        a_ext_en = 16'hFFFF; a_ext_data = 16'h1111;
        dir_atob = 2'b11; sel_ab_reg = 2'b00; sel_ba_reg = 2'b00; out_en = 2'b11; #1;
        chk("R7", "baseline", b_line, 16'h1111);
        sel_ba_reg = 2'b11; #1;
        chk("R7", "sel_ba ignored on B", b_line, 16'h1111);
        chk("R7", "sel_ba ignored on A", a_line, 16'h1111);
        sel_ab_reg = 2'b11; sel_ba_reg = 2'b00; #1;
        chk("R7", "sel_ba ignored stored", b_line, 16'h5AA5);
        tick();
    endtask

    task automatic t_keeper();
        // block currently drives B with 5AA5 and has been latched for one edge
        out_en = 2'b00; #1;
        chk("R8", "B holds block level", b_line, 16'h5AA5);
        chk("R3", "no drive", {a_drv_en, b_drv_en}, 4'b0000);
        tick(); tick();
        chk("R8", "B still held", b_line, 16'h5AA5);
        a_ext_data = 16'hC3C3; a_ext_en = 16'hFFFF;
        tick();
        a_ext_en = 16'h00FF; a_ext_data = 16'h0000; #1;
        chk("R8", "partial release", a_line, 16'hC300);
        a_ext_data = 16'h007E;
        tick();
        chk("R8", "held upper, live lower", a_line, 16'hC37E);
        a_ext_en = 16'h0000; #1;
        chk("R8", "full release", a_line, 16'hC37E);
    endtask

    task automatic t_halves();
        out_en = 2'b00; b_ext_en = '0;
        a_ext_en = 16'hFFFF; a_ext_data = 16'h6699;
        dir_atob = 2'b11; sel_ab_reg = 2'b00; out_en = 2'b01; #1;
        chk("R1", "half0 passes", b_line[7:0], 8'h99);
        chk("R1", "half1 untouched", b_line[15:8], 8'h5A);
        chk("R1", "drive flags", {a_drv_en, b_drv_en}, 4'b0001);
        tick();
        out_en = 2'b10; #1;
        chk("R1", "half1 passes", b_line[15:8], 8'h66);
        chk("R1", "half0 held", b_line[7:0], 8'h99);
        out_en = 2'b00;
        tick();
    endtask

    initial begin
        t_reset();
        t_transparent_ab();
        t_store_ab();
        t_store_ba();
        t_unused_sel();
        t_keeper();
        t_halves();
        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1'b1;
            total++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule